// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the receiving end of a four-byte serial programming link. A host drives a serial clock and a data line into the block, and the block answers on a return data line. The three serial pins are asynchronous to the system clock. The block samples them in the system clock domain through two-flop synchronisers and detects the clock edges there. An active-high programming reset pin restarts the frame alignment and drops the session.

Every instruction is exactly 32 bits long, sent most significant bit first. The block captures incoming bits on rising serial clock edges and moves the return line only after falling edges. Nothing is accepted until a programming-enable instruction arrives with the correct second byte. If the second byte is wrong, the block stays out of sync until the host pulses the reset pin and sends a new enable. Once enabled, the block carries out chip erase, reads and writes against a small program array and a small EEPROM array.

Writes and erase are self-timed. During that time a busy flag is high and any instruction that completes is discarded. The serial pins carry no back-pressure: the host paces the link and must respect the busy flag. The block has no valid/ready stream port.

Top module: `serprog_target`

## Requirements
- R1: After system reset, `miso_o`, `busy_o` and `enabled_o` are all 0, and every location of both arrays reads 0xFF.
- R2: An instruction 0xAC 0x53 xx xx sets `enabled_o`. While the third byte shifts in, `miso_o` returns the received second byte, MSB first.
- R3: An enable instruction whose second byte is not 0x53 leaves `enabled_o` at 0, but the echo still returns the byte received. While `enabled_o` is 0, every instruction other than enable is ignored, and a read returns 0x00.
- R4: A high pulse on `prog_rst_i` clears `enabled_o`, discards a partly received frame and realigns framing to the next bit.
- R5: 0x20 aH aL xx reads the program array and 0xA0 aH aL xx reads the EEPROM array. The data byte is returned during the fourth byte. The index is the low bits of {aH,aL}, so addresses wrap at the array depth.
- R6: 0x40 aH aL dd writes the program array without erasing first: the stored byte becomes old AND dd.
- R7: 0xC0 aH aL dd writes the EEPROM with a built-in erase: the stored byte becomes dd, whatever it held before.
- R8: 0xAC 0x80 xx xx, when enabled, sets every location of both arrays to 0xFF.
- R9: Each accepted write or erase holds `busy_o` high for exactly WR_CYCLES system clocks. An instruction that completes while busy is ignored.
- R10: The block works with serial clock low and high phases of MIN_PHASE_CLKS system clocks: 3 when FAST_CLK=0, 4 when FAST_CLK=1.
- R11: `miso_o` changes only in the cycle after a detected falling serial clock edge, or on a programming reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| mosi_i | input | 1 | Serial data from host, asynchronous |
| prog_rst_i | input | 1 | Active-high programming reset, asynchronous |
| miso_o | output | 1 | Serial data to host |
| busy_o | output | 1 | Self-timed write or erase in progress |
| enabled_o | output | 1 | Session enabled (in sync) |

## Verification
The assertions watch timing rules on every cycle:
- the return line moves only after a detected falling edge or a reset;
- each busy period lasts exactly WR_CYCLES;
- busy starts only while enabled, and enable rises only at a frame boundary;
- a programming reset drops the session;
- the host keeps each serial clock phase at least MIN_PHASE_CLKS long.

Only the bench scenarios can show that the data path is right:
- the echo byte and the read data;
- the AND rule for program writes against replacement for EEPROM writes;
- the erase fill, address wrap, and the discarding of instructions while out of sync or busy.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam logic [7:0] OP_SESSION = 8'hAC;
  localparam logic [7:0] KEY_SYNC   = 8'h53;
  localparam logic [7:0] SUB_ERASE  = 8'h80;
  localparam logic [7:0] OP_RD_PROG = 8'h20;
  localparam logic [7:0] OP_RD_EE   = 8'hA0;
  localparam logic [7:0] OP_WR_PROG = 8'h40;
  localparam logic [7:0] OP_WR_EE   = 8'hC0;
  localparam logic [7:0] ERASED     = 8'hFF;

  typedef enum logic [1:0] {
    SLOT_OPC  = 2'd0,
    SLOT_AHI  = 2'd1,
    SLOT_ALO  = 2'd2,
    SLOT_DATA = 2'd3
  } slot_e;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic             rise0_o,
  output logic             fall0_o
);
  logic [WIDTH-1:0] chain [STAGES];
  logic             last0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      last0 <= 1'b0;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      last0 <= chain[STAGES-1][0];
    end
  end

  assign sync_o  = chain[STAGES-1];
  assign rise0_o = chain[STAGES-1][0] & ~last0;
  assign fall0_o = ~chain[STAGES-1][0] & last0;
endmodule

// File: rtl/serprog_frame.sv
module serprog_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       bit_i,
  input  logic [7:0] reply_i,
  output logic       byte_done_o,
  output logic [1:0] byte_idx_o,
  output logic [7:0] byte_o,
  output logic       miso_o
);
  logic [4:0] bitcnt;
  logic [6:0] rx;
  logic [7:0] tx, next_tx;
  logic       pend;

  assign byte_done_o = rise_i && (bitcnt[2:0] == 3'd7);
  assign byte_idx_o  = bitcnt[4:3];
  assign byte_o      = {rx, bit_i};
  assign miso_o      = tx[7];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      bitcnt  <= '0;
      rx      <= '0;
      tx      <= '0;
      next_tx <= '0;
      pend    <= 1'b0;
    end else begin
      if (rise_i) begin
        rx     <= {rx[5:0], bit_i};
        bitcnt <= bitcnt + 5'd1;
        if (byte_done_o) begin
          pend    <= 1'b1;
          next_tx <= reply_i;
        end
      end
      if (fall_i) begin
        if (pend) begin
          tx   <= next_tx;
          pend <= 1'b0;
        end else begin
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/serprog_exec.sv
module serprog_exec
  import serprog_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  parameter int EE_DEPTH   = 8,
  parameter int WR_CYCLES  = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       byte_done_i,
  input  logic [1:0] byte_idx_i,
  input  logic [7:0] byte_i,
  output logic [7:0] reply_o,
  output logic       frame_done_o,
  output logic       busy_o,
  output logic       enabled_o
);
  localparam int PAW = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1;
  localparam int EAW = (EE_DEPTH > 1) ? $clog2(EE_DEPTH) : 1;
  localparam int BW  = $clog2(WR_CYCLES + 1);

  logic [7:0]    prog_mem [PROG_DEPTH];
  logic [7:0]    ee_mem   [EE_DEPTH];
  logic [7:0]    opc, ahi, alo;
  logic [BW-1:0] busy_cnt;
  logic          accept;
  logic [PAW-1:0] p_rd, p_wr;
  logic [EAW-1:0] e_rd, e_wr;

  assign accept       = enabled_o && !busy_o;
  assign busy_o       = (busy_cnt != '0);
  assign frame_done_o = byte_done_i && (byte_idx_i == SLOT_DATA);
  assign p_rd = PAW'({ahi, byte_i} % PROG_DEPTH);
  assign e_rd = EAW'({ahi, byte_i} % EE_DEPTH);
  assign p_wr = PAW'({ahi, alo} % PROG_DEPTH);
  assign e_wr = EAW'({ahi, alo} % EE_DEPTH);

  always_comb begin
    reply_o = 8'h00;
    if (byte_idx_i == SLOT_AHI && opc == OP_SESSION) reply_o = byte_i;
    else if (byte_idx_i == SLOT_ALO && accept) begin
      if (opc == OP_RD_PROG)    reply_o = prog_mem[p_rd];
      else if (opc == OP_RD_EE) reply_o = ee_mem[e_rd];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc <= '0; ahi <= '0; alo <= '0;
      enabled_o <= 1'b0;
      busy_cnt  <= '0;
      for (int i = 0; i < PROG_DEPTH; i++) prog_mem[i] <= ERASED;
      for (int i = 0; i < EE_DEPTH; i++)   ee_mem[i]   <= ERASED;
    end else begin
      if (busy_o) busy_cnt <= busy_cnt - 1'b1;
      if (clr_i) begin
        opc <= '0; ahi <= '0; alo <= '0;
        enabled_o <= 1'b0;
      end else if (byte_done_i) begin
        case (byte_idx_i)
          SLOT_OPC: opc <= byte_i;
          SLOT_AHI: ahi <= byte_i;
          SLOT_ALO: alo <= byte_i;
          default: begin
            if (opc == OP_SESSION && ahi == KEY_SYNC && !busy_o) enabled_o <= 1'b1;
            if (accept) begin
              if (opc == OP_SESSION && ahi == SUB_ERASE) begin
                for (int i = 0; i < PROG_DEPTH; i++) prog_mem[i] <= ERASED;
                for (int i = 0; i < EE_DEPTH; i++)   ee_mem[i]   <= ERASED;
                busy_cnt <= BW'(WR_CYCLES);
              end else if (opc == OP_WR_PROG) begin
                prog_mem[p_wr] <= prog_mem[p_wr] & byte_i;
                busy_cnt <= BW'(WR_CYCLES);
              end else if (opc == OP_WR_EE) begin
                ee_mem[e_wr] <= byte_i;
                busy_cnt <= BW'(WR_CYCLES);
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/serprog_target.sv
module serprog_target #(
  parameter int PROG_DEPTH = 16,
  parameter int EE_DEPTH   = 8,
  parameter int WR_CYCLES  = 300,
  parameter bit FAST_CLK   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic prog_rst_i,
  output logic miso_o,
  output logic busy_o,
  output logic enabled_o
);
  localparam int MIN_PHASE_CLKS = FAST_CLK ? 4 : 3;

  logic [2:0] pins_s;
  logic       sck_rise, sck_fall, prst_s;
  logic       byte_done, frame_done;
  logic [1:0] byte_idx;
  logic [7:0] byte_val, reply;

  serprog_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({prog_rst_i, mosi_i, sck_i}),
    .sync_o(pins_s), .rise0_o(sck_rise), .fall0_o(sck_fall)
  );
  assign prst_s = pins_s[2];

  serprog_frame u_frame (
    .clk(clk), .rst_n(rst_n), .clr_i(prst_s),
    .rise_i(sck_rise), .fall_i(sck_fall), .bit_i(pins_s[1]),
    .reply_i(reply), .byte_done_o(byte_done), .byte_idx_o(byte_idx),
    .byte_o(byte_val), .miso_o(miso_o)
  );

  serprog_exec #(.PROG_DEPTH(PROG_DEPTH), .EE_DEPTH(EE_DEPTH), .WR_CYCLES(WR_CYCLES)) u_exec (
    .clk(clk), .rst_n(rst_n), .clr_i(prst_s),
    .byte_done_i(byte_done), .byte_idx_i(byte_idx), .byte_i(byte_val),
    .reply_o(reply), .frame_done_o(frame_done),
    .busy_o(busy_o), .enabled_o(enabled_o)
  );
endmodule

// File: rtl/serprog_target_chk.sv
module serprog_target_chk #(
  parameter int WR_CYCLES = 300,
  parameter int MIN_PHASE = 3
) (
  input logic clk,
  input logic rst_n,
  input logic sck_rise,
  input logic sck_fall,
  input logic prst_s,
  input logic frame_done,
  input logic miso_o,
  input logic busy_o,
  input logic enabled_o
);
  int unsigned busy_run;
  int unsigned phase_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_run  <= 0;
      phase_run <= MIN_PHASE;
    end else begin
      busy_run  <= busy_o ? busy_run + 1 : 0;
      if (sck_rise || sck_fall) phase_run <= 1;
      else if (phase_run < MIN_PHASE) phase_run <= phase_run + 1;
    end
  end

  // R11: the return line moves only after a detected falling edge or a reset
  assert_miso_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !prst_s) |=> $stable(miso_o));

  // R4: a synchronised programming reset drops the session
  assert_reset_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prst_s |=> !enabled_o);

  // R2: the session is enabled only at a frame boundary
  assert_enable_at_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enabled_o) |-> $past(frame_done));

  // R9: busy starts only from an enabled session
  assert_busy_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(enabled_o));

  // R9: each busy period lasts exactly WR_CYCLES
  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == WR_CYCLES));

  // R10: each serial clock phase lasts at least the minimum
  assert_phase_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise || sck_fall) |-> (phase_run >= MIN_PHASE));
endmodule

bind serprog_target serprog_target_chk #(.WR_CYCLES(WR_CYCLES), .MIN_PHASE(MIN_PHASE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
  .prst_s(prst_s), .frame_done(frame_done), .miso_o(miso_o),
  .busy_o(busy_o), .enabled_o(enabled_o)
);

// File: tb/serprog_target_bench.sv
module serprog_target_bench;
  localparam int WR = 300;
  localparam int PH = 3;
  localparam int EE_D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, prst = 1'b0;
  logic miso, busy, enabled;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serprog_target #(.PROG_DEPTH(16), .EE_DEPTH(EE_D), .WR_CYCLES(WR), .FAST_CLK(1'b0)) u_serprog_target (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .prog_rst_i(prst),
    .miso_o(miso), .busy_o(busy), .enabled_o(enabled)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sends n bits of w (from bit 31 down), collects returned bits
  task automatic send(input logic [31:0] w, input int n, output logic [31:0] r, output bit hold_ok);
    logic v;
    r = '0; hold_ok = 1'b1;
    for (int i = 31; i > 31 - n; i--) begin
      sck = 1'b0; mosi = w[i];
      repeat (PH) @(negedge clk);
      v = miso; r = {r[30:0], v};
      sck = 1'b1;
      repeat (PH) @(negedge clk);
      if (miso !== v) hold_ok = 1'b0;
    end
  endtask

  task automatic xfer(input logic [31:0] w, output logic [31:0] r);
    bit ok;
    send(w, 32, r, ok);
    check("R11 miso held through high phase", ok, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulse_prog_reset();
    prst = 1'b1; repeat (4) @(negedge clk);
    prst = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic read_byte(input logic [7:0] op, input int addr, output logic [7:0] d);
    logic [31:0] r;
    xfer({op, 8'(addr >> 8), 8'(addr), 8'h00}, r);
    d = r[7:0];
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 miso after reset", miso, 0);
    check("R1 busy after reset", busy, 0);
    check("R1 enabled after reset", enabled, 0);
    read_byte(8'h20, 1, d);
    check("R3 read ignored while out of sync", d, 8'h00);
  endtask

  task automatic t_bad_enable();
    logic [31:0] r; logic [7:0] d;
    xfer(32'hAC52_0000, r);
    check("R3 echo of wrong second byte", r[15:8], 8'h52);
    check("R3 enable refused", enabled, 0);
    xfer(32'hC001_0077, r);
    check("R3 write ignored while out of sync", busy, 0);
    pulse_prog_reset();
  endtask

  task automatic t_enable();
    logic [31:0] r; logic [7:0] d;
    xfer(32'hAC53_0000, r);
    check("R2 echo of sync byte", r[15:8], 8'h53);
    check("R2 R10 enabled at minimum phase", enabled, 1);
    read_byte(8'h20, 5, d);
    check("R1 R5 program reads erased", d, 8'hFF);
    read_byte(8'hA0, 1, d);
    check("R1 R5 EEPROM reads erased; R3 earlier write ignored", d, 8'hFF);
  endtask

  task automatic t_prog_write();
    logic [31:0] r; logic [7:0] d; int cnt;
    xfer(32'h4000_05F0, r);
    check("R9 busy right after write", busy, 1);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R9 busy length", cnt, WR);
    xfer(32'h4000_053C, r); wait_idle();
    read_byte(8'h20, 5, d);
    check("R6 program write ANDs", d, 8'h30);
  endtask

  task automatic t_ee_write();
    logic [31:0] r; logic [7:0] d;
    xfer(32'hC000_0312, r); wait_idle();
    xfer(32'hC000_0334, r); wait_idle();
    read_byte(8'hA0, 3, d);
    check("R7 EEPROM write replaces", d, 8'h34);
    read_byte(8'hA0, EE_D + 3, d);
    check("R5 address wraps at depth", d, 8'h34);
    xfer(32'hC000_020F, r);
    xfer(32'hC000_02AA, r);
    wait_idle();
    read_byte(8'hA0, 2, d);
    check("R9 write while busy ignored", d, 8'h0F);
  endtask

  task automatic t_erase();
    logic [31:0] r; logic [7:0] d;
    xfer(32'hAC80_0000, r);
    check("R8 erase sets busy", busy, 1);
    wait_idle();
    read_byte(8'h20, 5, d);
    check("R8 program erased", d, 8'hFF);
    read_byte(8'hA0, 3, d);
    check("R8 EEPROM erased", d, 8'hFF);
  endtask

  task automatic t_partial_reset();
    logic [31:0] r; logic [7:0] d; bit ok;
    xfer(32'hC000_0466, r); wait_idle();
    send(32'hA000_0400, 12, r, ok);
    pulse_prog_reset();
    check("R4 reset drops session", enabled, 0);
    sck = 1'b0; repeat (PH) @(negedge clk);
    xfer(32'hAC53_0000, r);
    check("R4 realigned enable", enabled, 1);
    read_byte(8'hA0, 4, d);
    check("R4 framing realigned read", d, 8'h66);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bad_enable();
    t_enable();
    t_prog_write();
    t_ee_write();
    t_erase();
    t_partial_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule